// File: doc/BRIEF.md
# SIMT Warp Issue and Lane Serializer

This block takes one warp-wide instruction at a time and applies it to every thread of a warp in lockstep. Each thread owns one destination word and two operand words. The operand words arrive as flat vectors with the instruction. An active-thread mask decides which threads may write. Every instruction names an operation class: integer, single-width float or double-width float. Each class has its own parameterised number of physical lanes. When a class has fewer lanes than the warp has threads, the instruction is cut into consecutive beats. Beat k covers threads k·L up to k·L+L−1, and the last beat may be only partly filled. The per-lane arithmetic is an integer add or multiply that stands in for the real datapath.

A branch command carries a per-thread predicate and two operations. The taken path runs first under active AND predicate, and the fall-through path runs next under active AND NOT predicate. The saved active mask is in force again once both paths are done. A path whose mask is empty is skipped and takes no beats. A set-mask command loads the active mask. A ready/valid handshake holds off new work while beats or serialized paths are still running. A done pulse marks the final beat of each instruction. A counter adds up how many threads write in every beat, which makes lane utilisation measurable.

Top module: `warp_issue_unit`

## Requirements
- R1: After reset the active mask is all ones, every destination word and the utilisation counter are zero, in_ready is 1 and done_o is 0.
- R2: An instruction accepted at a clock edge whose class has at least WARP lanes completes in one beat. done_o is high during the cycle after the edge and in_ready stays high in that cycle, so one warp instruction can be accepted per clock.
- R3: An instruction of a class with L lanes takes ceil(WARP/L) beats, and done_o is high in the last one. in_ready is 0 in every beat except the final one.
- R4: Beat k writes only threads k·L through min(k·L+L, WARP)−1, and each beat's results are visible at res_o after the clock edge that ends that beat.
- R5: A thread whose bit in the path mask is 0 keeps its destination word unchanged.
- R6: in_cmd=1 (branch) runs the A operation under active AND in_pred, then the B operation under active AND NOT in_pred. The total beat count is the sum of both paths' beats.
- R7: A branch path whose mask is all zeros is skipped and adds no beats.
- R8: A branch whose two path masks are both empty writes nothing. done_o pulses in the cycle after acceptance and in_ready stays 1.
- R9: in_cmd=2 (set-mask) loads in_pred into the active mask, which is visible from the cycle after acceptance, and raises no done pulse. Branches and plain instructions leave the active mask unchanged.
- R10: In every beat util_o grows by the number of threads written in that beat, and it does not change in cycles with no beat.
- R11: in_op=0 gives a+b and in_op=1 gives a·b, truncated to DW bits. Class codes are 0 integer, 1 single float and 2 double float, and code 3 uses the integer lane count.
- R12: Operands are captured at acceptance. Changing in_opa and in_opb afterwards does not alter the results of the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be accepted this cycle |
| in_cmd | input | 2 | 0 execute, 1 branch, 2 set mask, 3 no-op |
| in_cls_a | input | 2 | Operation class of the execute or taken path |
| in_op_a | input | 1 | Arithmetic op of the execute or taken path |
| in_cls_b | input | 2 | Operation class of the fall-through path |
| in_op_b | input | 1 | Arithmetic op of the fall-through path |
| in_pred | input | WARP | Branch predicate, or the new mask for set-mask |
| in_opa | input | WARP*DW | First operand of every thread, thread t at bits t*DW |
| in_opb | input | WARP*DW | Second operand of every thread |
| done_o | output | 1 | Final beat of an instruction |
| active_o | output | WARP | Current active-thread mask |
| res_o | output | WARP*DW | Destination word of every thread |
| util_o | output | UTIL_W | Running count of thread writes |

## Verification
The bench builds the block with 16 integer lanes, 32 single-float lanes and 12 double-float lanes. This gives single-beat, even two-beat and three-beat operations within one run, and in the three-beat case the last beat holds only 8 threads. With those values, back-to-back one-per-clock issue, ready held low mid-instruction, partial results beat by beat, and branch paths of unequal length can all be observed at the ports. The three branch shapes are run: both paths live, one path empty, and both paths empty.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  localparam logic [1:0] CMD_EXEC    = 2'd0;
  localparam logic [1:0] CMD_BRANCH  = 2'd1;
  localparam logic [1:0] CMD_SETMASK = 2'd2;
  localparam logic [1:0] CMD_NOP     = 2'd3;

  localparam logic [1:0] CLS_INT  = 2'd0;
  localparam logic [1:0] CLS_FP32 = 2'd1;
  localparam logic [1:0] CLS_FP64 = 2'd2;

  localparam logic OP_ADD = 1'b0;
  localparam logic OP_MUL = 1'b1;

  typedef struct packed {
    logic [1:0] cls;
    logic       op;
  } path_op_t;
endpackage

// File: rtl/warp_seq_ctrl.sv
module warp_seq_ctrl
  import warp_issue_pkg::*;
#(
  parameter int WARP  = 32,
  parameter int INT_L = 32,
  parameter int FP_L  = 16,
  parameter int DP_L  = 4,
  localparam int BW = $clog2(WARP + 1),
  localparam int TW = $clog2(WARP) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_cmd,
  input  path_op_t        path_a,
  input  path_op_t        path_b,
  input  logic [WARP-1:0] in_pred,
  output logic            in_ready,
  output logic            cap_en,
  output logic            run,
  output logic            done,
  output logic [WARP-1:0] active,
  output logic [WARP-1:0] mask_now,
  output logic            op_now,
  output logic [TW-1:0]   base,
  output logic [TW-1:0]   lanes
);

  function automatic int lanes_int(input logic [1:0] c);
    case (c)
      CLS_FP32: return FP_L;
      CLS_FP64: return DP_L;
      default:  return INT_L;
    endcase
  endfunction

  function automatic logic [BW-1:0] beats_of(input logic [1:0] c);
    int l;
    l = lanes_int(c);
    return BW'((WARP + l - 1) / l);
  endfunction

  logic            run_q, run_n;
  logic            phase_q, phase_n;
  logic            has_b_q, has_b_n;
  logic            empty_q, empty_n;
  logic [BW-1:0]   beat_q, beat_n;
  logic [WARP-1:0] mask_a_q, mask_a_n;
  logic [WARP-1:0] mask_b_q, mask_b_n;
  logic [WARP-1:0] active_q, active_n;
  path_op_t        pa_q, pa_n, pb_q, pb_n;

  logic            accept;
  logic            last_beat;
  logic            final_c;
  logic [1:0]      cls_now;
  logic [WARP-1:0] br_a, br_b;

  assign cls_now   = phase_q ? pb_q.cls : pa_q.cls;
  assign op_now    = phase_q ? pb_q.op  : pa_q.op;
  assign mask_now  = phase_q ? mask_b_q : mask_a_q;
  assign lanes     = TW'(lanes_int(cls_now));
  assign base      = TW'(32'(beat_q) * 32'(lanes));
  assign last_beat = (beat_q == (beats_of(cls_now) - BW'(1)));
  assign final_c   = run_q && last_beat && (phase_q || !has_b_q);

  assign in_ready = !run_q || final_c;
  assign accept   = in_valid && in_ready;
  assign cap_en   = accept && ((in_cmd == CMD_EXEC) || (in_cmd == CMD_BRANCH));
  assign done     = final_c || empty_q;
  assign run      = run_q;
  assign active   = active_q;

  assign br_a = active_q & in_pred;
  assign br_b = active_q & ~in_pred;

  always_comb begin
    run_n    = run_q;
    phase_n  = phase_q;
    has_b_n  = has_b_q;
    beat_n   = beat_q;
    mask_a_n = mask_a_q;
    mask_b_n = mask_b_q;
    active_n = active_q;
    pa_n     = pa_q;
    pb_n     = pb_q;
    empty_n  = 1'b0;

    if (run_q) begin
      if (last_beat) begin
        if (!phase_q && has_b_q) begin
          phase_n = 1'b1;
          beat_n  = '0;
        end else begin
          run_n = 1'b0;
        end
      end else begin
        beat_n = beat_q + BW'(1);
      end
    end

    if (accept) begin
      case (in_cmd)
        CMD_EXEC: begin
          pa_n     = path_a;
          run_n    = 1'b1;
          phase_n  = 1'b0;
          has_b_n  = 1'b0;
          beat_n   = '0;
          mask_a_n = active_q;
        end
        CMD_BRANCH: begin
          pa_n     = path_a;
          pb_n     = path_b;
          mask_a_n = br_a;
          mask_b_n = br_b;
          has_b_n  = |br_b;
          beat_n   = '0;
          if (|br_a) begin
            run_n   = 1'b1;
            phase_n = 1'b0;
          end else if (|br_b) begin
            run_n   = 1'b1;
            phase_n = 1'b1;
          end else begin
            empty_n = 1'b1;
          end
        end
        CMD_SETMASK: active_n = in_pred;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      phase_q  <= 1'b0;
      has_b_q  <= 1'b0;
      empty_q  <= 1'b0;
      beat_q   <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
      active_q <= '1;
      pa_q     <= '0;
      pb_q     <= '0;
    end else begin
      run_q    <= run_n;
      phase_q  <= phase_n;
      has_b_q  <= has_b_n;
      empty_q  <= empty_n;
      beat_q   <= beat_n;
      mask_a_q <= mask_a_n;
      mask_b_q <= mask_b_n;
      active_q <= active_n;
      pa_q     <= pa_n;
      pb_q     <= pb_n;
    end
  end

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready); // R2
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !final_c) |=> $stable(active_q)); // R9
  AST_PATHS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && has_b_q) |-> ((mask_a_q & mask_b_q) == '0)); // R6
  AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && phase_q) |-> (mask_b_q != '0)); // R7

endmodule

// File: rtl/warp_lane_array.sv
module warp_lane_array
  import warp_issue_pkg::*;
#(
  parameter int WARP = 32,
  parameter int DW   = 16,
  parameter int MAXL = 32,
  localparam int TW = $clog2(WARP) + 1
) (
  input  logic [WARP*DW-1:0] opa,
  input  logic [WARP*DW-1:0] opb,
  input  logic [TW-1:0]      base,
  input  logic [TW-1:0]      lanes,
  input  logic               op,
  output logic [MAXL*DW-1:0] lane_res
);

  for (genvar i = 0; i < MAXL; i++) begin : g_lane
    logic [TW-1:0] idx;
    logic [TW-1:0] idx_c;
    logic          ok;
    logic [DW-1:0] a, b;

    always_comb begin
      idx   = base + TW'(i);
      ok    = (TW'(i) < lanes) && (idx < TW'(WARP));
      idx_c = ok ? idx : '0;
      a     = opa[idx_c*DW +: DW];
      b     = opb[idx_c*DW +: DW];
      if (op == OP_MUL) lane_res[i*DW +: DW] = a * b;
      else              lane_res[i*DW +: DW] = a + b;
    end
  end

endmodule

// File: rtl/warp_util_ctr.sv
module warp_util_ctr #(
  parameter int WARP = 32,
  parameter int UW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [WARP-1:0] we,
  output logic [UW-1:0]   util
);

  logic [UW-1:0] util_q, util_n;
  logic          cnt_en;

  assign cnt_en = run;

  always_comb begin
    util_n = util_q;
    if (cnt_en) util_n = util_q + UW'($countones(we));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) util_q <= '0;
    else        util_q <= util_n;
  end

  assign util = util_q;

  AST_UTIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(util_q)); // R10

endmodule

// File: rtl/warp_issue_unit.sv
module warp_issue_unit
  import warp_issue_pkg::*;
#(
  parameter int WARP       = 32,
  parameter int DW         = 16,
  parameter int INT_LANES  = 32,
  parameter int FP32_LANES = 16,
  parameter int FP64_LANES = 4,
  parameter int UTIL_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_cmd,
  input  logic [1:0]         in_cls_a,
  input  logic               in_op_a,
  input  logic [1:0]         in_cls_b,
  input  logic               in_op_b,
  input  logic [WARP-1:0]    in_pred,
  input  logic [WARP*DW-1:0] in_opa,
  input  logic [WARP*DW-1:0] in_opb,
  output logic               done_o,
  output logic [WARP-1:0]    active_o,
  output logic [WARP*DW-1:0] res_o,
  output logic [UTIL_W-1:0]  util_o
);

  localparam int TW    = $clog2(WARP) + 1;
  localparam int MAX01 = (INT_LANES > FP32_LANES) ? INT_LANES : FP32_LANES;
  localparam int MAXL  = (MAX01 > FP64_LANES) ? MAX01 : FP64_LANES;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  path_op_t        path_a, path_b;
  logic            cap_en, run, op_now;
  logic [WARP-1:0] mask_now;
  logic [TW-1:0]   base, lanes;

  assign path_a = '{cls: in_cls_a, op: in_op_a};
  assign path_b = '{cls: in_cls_b, op: in_op_b};

  warp_seq_ctrl #(
    .WARP (WARP),
    .INT_L(INT_LANES),
    .FP_L (FP32_LANES),
    .DP_L (FP64_LANES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .in_valid(in_valid),
    .in_cmd  (in_cmd),
    .path_a  (path_a),
    .path_b  (path_b),
    .in_pred (in_pred),
    .in_ready(in_ready),
    .cap_en  (cap_en),
    .run     (run),
    .done    (done_o),
    .active  (active_o),
    .mask_now(mask_now),
    .op_now  (op_now),
    .base    (base),
    .lanes   (lanes)
  );

  logic [WARP*DW-1:0] opa_q, opb_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (cap_en) begin
      opa_q <= in_opa;
      opb_q <= in_opb;
    end
  end

  logic [MAXL*DW-1:0] lane_res;

  warp_lane_array #(
    .WARP(WARP),
    .DW  (DW),
    .MAXL(MAXL)
  ) u_lanes (
    .opa     (opa_q),
    .opb     (opb_q),
    .base    (base),
    .lanes   (lanes),
    .op      (op_now),
    .lane_res(lane_res)
  );

  logic [WARP-1:0]    we;
  logic [WARP*DW-1:0] res_q;

  for (genvar t = 0; t < WARP; t++) begin : g_thr
    logic [TW-1:0] off;
    logic          in_win;
    logic [DW-1:0] wdat;

    always_comb begin
      off    = TW'(t) - base;
      in_win = (TW'(t) >= base) && (off < lanes);
      we[t]  = run && in_win && mask_now[t];
      wdat   = in_win ? lane_res[off*DW +: DW] : '0;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)   res_q[t*DW +: DW] <= '0;
      else if (we[t]) res_q[t*DW +: DW] <= wdat;
    end

    AST_IDLE_THREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
      !(run && mask_now[t]) |=> $stable(res_q[t*DW +: DW])); // R5
  end

  assign res_o = res_q;

  warp_util_ctr #(
    .WARP(WARP),
    .UW  (UTIL_W)
  ) u_util (
    .clk  (clk),
    .rst_n(rst_i_n),
    .run  (run),
    .we   (we),
    .util (util_o)
  );

endmodule

// File: tb/warp_issue_unit_tb.sv
module warp_issue_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int DW = 16;
  localparam int IL = 16;
  localparam int FL = 32;
  localparam int DL = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [1:0]      in_cmd = '0;
  logic [1:0]      in_cls_a = '0, in_cls_b = '0;
  logic            in_op_a = 1'b0, in_op_b = 1'b0;
  logic [W-1:0]    in_pred = '0;
  logic [W*DW-1:0] in_opa = '0, in_opb = '0;
  logic            done_o;
  logic [W-1:0]    active_o;
  logic [W*DW-1:0] res_o;
  logic [31:0]     util_o;

  warp_issue_unit #(
    .WARP(W), .DW(DW), .INT_LANES(IL), .FP32_LANES(FL), .FP64_LANES(DL), .UTIL_W(32)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_cls_a(in_cls_a), .in_op_a(in_op_a),
    .in_cls_b(in_cls_b), .in_op_b(in_op_b), .in_pred(in_pred),
    .in_opa(in_opa), .in_opb(in_opb), .done_o(done_o), .active_o(active_o),
    .res_o(res_o), .util_o(util_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W*DW-1:0] m_res = '0;
  logic [W-1:0]    m_act = '1;
  int              m_util = 0;

  logic [W*DW-1:0] q_res[$];
  int              q_cyc[$];
  int              q_acc[$];
  int              q_util[$];
  string           q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic int beats(input logic [1:0] c);
    int l;
    l = (c == 2'd1) ? FL : (c == 2'd2) ? DL : IL;
    return (W + l - 1) / l;
  endfunction

  function automatic logic [DW-1:0] alu(input logic op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    return op ? DW'(a * b) : DW'(a + b);
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Driver: computes the expected outcome and pushes it before the accepting edge.
  task automatic issue(input logic [1:0] cmd, input logic [1:0] ca, input logic oa,
                       input logic [1:0] cb, input logic ob, input logic [W-1:0] pred,
                       input int seed, input string tag);
    logic [W-1:0] ma, mb;
    int ncyc;
    in_cmd = cmd; in_cls_a = ca; in_op_a = oa; in_cls_b = cb; in_op_b = ob;
    in_pred = pred;
    for (int t = 0; t < W; t++) begin
      in_opa[t*DW +: DW] = DW'(seed * 97 + t * 13 + 5);
      in_opb[t*DW +: DW] = DW'(seed * 31 + t * 7 + 3);
    end
    in_valid = 1'b1;
    while (!in_ready) step();
    if (cmd == 2'd0 || cmd == 2'd1) begin
      if (cmd == 2'd0) begin
        ma = m_act; mb = '0;
        ncyc = beats(ca);
      end else begin
        ma = m_act & pred; mb = m_act & ~pred;
        ncyc = ((ma != 0) ? beats(ca) : 0) + ((mb != 0) ? beats(cb) : 0);
        if (ncyc == 0) ncyc = 1;
      end
      for (int t = 0; t < W; t++) begin
        if (ma[t]) m_res[t*DW +: DW] = alu(oa, in_opa[t*DW +: DW], in_opb[t*DW +: DW]);
        else if (mb[t]) m_res[t*DW +: DW] = alu(ob, in_opa[t*DW +: DW], in_opb[t*DW +: DW]);
      end
      m_util += $countones(ma) + $countones(mb);
      q_res.push_back(m_res); q_cyc.push_back(ncyc); q_acc.push_back(cyc + 1);
      q_util.push_back(m_util); q_tag.push_back(tag);
    end else if (cmd == 2'd2) begin
      m_act = pred;
    end
    step();
    in_valid = 1'b0;
    in_opa = ~in_opa;   // R12: operands changed after acceptance
    in_opb = ~in_opb;
  endtask

  // Monitor: pops one expected item per done pulse.
  logic [W*DW-1:0] p_res;
  int              p_util;
  string           p_tag;
  bit              pend = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        int bad;
        bad = -1;
        for (int t = W - 1; t >= 0; t--)
          if (res_o[t*DW +: DW] !== p_res[t*DW +: DW]) bad = t;
        if (bad >= 0)
          chk(1'b0, "R4/R5/R11/R12", {p_tag, " result thread"},
              res_o[bad*DW +: DW], p_res[bad*DW +: DW]);
        else chk(1'b1, "R11", p_tag, 0, 0);
        chk(util_o == 32'(p_util), "R10", {p_tag, " util"}, util_o, p_util);
        pend = 0;
      end
      if (done_o === 1'b1) begin
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R9", "done without pending instruction", 1, 0);
        end else begin
          int ec, ac;
          ec = q_cyc.pop_front(); ac = q_acc.pop_front();
          p_res = q_res.pop_front(); p_util = q_util.pop_front(); p_tag = q_tag.pop_front();
          chk(cyc - ac + 1 == ec, "R3/R6/R7/R8", {p_tag, " beats"}, cyc - ac + 1, ec);
          pend = 1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W*DW-1:0] pre;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    chk(res_o == '0, "R1", "res after reset", res_o[31:0], 0);
    chk(active_o == '1, "R1", "active after reset", active_o, 32'hffffffff);
    chk(util_o == 0, "R1", "util after reset", util_o, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);

    // R3 R11: integer add, two beats
    issue(2'd0, 2'd0, 1'b0, 2'd0, 1'b0, '0, 1, "int add");
    while (!in_ready) step();
    // R2: single-float back to back
    issue(2'd0, 2'd1, 1'b1, 2'd0, 1'b0, '0, 2, "fp32 mul");
    chk(in_ready == 1'b1, "R2", "ready in single-beat done cycle", in_ready, 1);
    issue(2'd0, 2'd1, 1'b0, 2'd0, 1'b0, '0, 3, "fp32 add");
    while (!in_ready) step();
    step();

    // R3 R4: three-beat double-float op with partial last beat
    pre = m_res;
    issue(2'd0, 2'd2, 1'b1, 2'd0, 1'b0, '0, 4, "fp64 mul");
    chk(in_ready == 1'b0, "R3", "ready in beat 0", in_ready, 0);
    step();
    chk(in_ready == 1'b0, "R3", "ready in beat 1", in_ready, 0);
    chk(res_o[11*DW +: DW] == m_res[11*DW +: DW], "R4", "thread 11 after beat 0",
        res_o[11*DW +: DW], m_res[11*DW +: DW]);
    chk(res_o[12*DW +: DW] == pre[12*DW +: DW], "R4", "thread 12 after beat 0",
        res_o[12*DW +: DW], pre[12*DW +: DW]);
    step();
    chk(in_ready == 1'b1, "R3", "ready in final beat", in_ready, 1);
    chk(res_o[23*DW +: DW] == m_res[23*DW +: DW], "R4", "thread 23 after beat 1",
        res_o[23*DW +: DW], m_res[23*DW +: DW]);
    chk(res_o[24*DW +: DW] == pre[24*DW +: DW], "R4", "thread 24 after beat 1",
        res_o[24*DW +: DW], pre[24*DW +: DW]);
    step();

    // R9 R5: partial active mask
    issue(2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 32'h0000ffff, 0, "setmask");
    chk(active_o == 32'h0000ffff, "R9", "active after set-mask", active_o, 32'h0000ffff);
    issue(2'd0, 2'd0, 1'b1, 2'd0, 1'b0, '0, 5, "masked int mul");
    issue(2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 32'hf0f0f0f0, 0, "setmask");
    issue(2'd0, 2'd3, 1'b0, 2'd0, 1'b0, '0, 6, "reserved class add");

    // R6: both paths live, active unchanged afterwards
    issue(2'd2, 2'd0, 1'b0, 2'd0, 1'b0, '1, 0, "setmask");
    issue(2'd1, 2'd0, 1'b0, 2'd2, 1'b1, 32'h0000ffff, 7, "branch 16/16");
    while (!in_ready) step();
    issue(2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 32'h3c3c00ff, 8, "branch uneven");
    while (!in_ready) step();
    step();
    chk(active_o == '1, "R9", "active restored after branch", active_o, 32'hffffffff);

    // R7: one empty path
    issue(2'd1, 2'd2, 1'b0, 2'd0, 1'b1, '1, 9, "branch else empty");
    issue(2'd1, 2'd2, 1'b0, 2'd0, 1'b1, '0, 10, "branch then empty");

    // R8: both paths empty
    issue(2'd2, 2'd0, 1'b0, 2'd0, 1'b0, '0, 0, "setmask");
    issue(2'd1, 2'd0, 1'b1, 2'd2, 1'b1, 32'h12345678, 11, "branch both empty");
    chk(in_ready == 1'b1, "R8", "ready during empty branch", in_ready, 1);
    issue(2'd0, 2'd2, 1'b0, 2'd0, 1'b0, '0, 12, "exec no active threads");

    while (q_cyc.size() != 0) step();
    repeat (3) step();
    summary();
    $finish;
  end
endmodule